// File: doc/BRIEF.md
# USB device event status register

This block keeps the event flags of a full-speed USB device controller. The protocol logic around it raises events: a finished endpoint transaction, a packet-memory access that was served too late, one of four line or protocol errors, resume activity, an idle bus, and a reset signalled on the bus. The block turns these events into sticky flags that software reads and clears over a small register bus. Bits 14 to 10 are cleared by writing 0, and writing 1 to them has no effect. Software can therefore clear exactly the events it has handled in one write, without read-modify-write races.

The transfer-complete flag is not sticky. It follows the endpoint-level completion condition and is read-only. While it is set, the block also holds the direction and endpoint index of the transaction that raised it. A separate mask register selects which flags drive the single interrupt line. While the bus-reset flag is set, the receive and transmit enables passed through the block are held low. Only a software clear of that flag lets traffic resume. The mask register has no link to bus-reset events, so it keeps its value across them.

Top module: `usb_evt_status`

## Requirements
- R1: Status bit 15 (transfer complete) equals the value of `xfer_done` one clock earlier. Bus writes have no effect on it.
- R2: In the cycle where `xfer_done` rises, status bit 4 captures `xfer_dir` and status bits 3:0 capture `xfer_ep`. Both fields then hold while `xfer_done` stays high, even if those inputs change.
- R3: A `pma_late` pulse sets status bit 14, which then stays set until software clears it.
- R4: Any one of `err_timeout`, `err_crc`, `err_stuff` or `err_frame` sets the single error flag in status bit 13.
- R5: `wake_evt` sets status bit 12, `susp_evt` sets bit 11 and `busrst_evt` sets bit 10. Each flag appears one clock after its event.
- R6: A write to address 0 clears each of bits 14..10 whose write-data bit is 0. It leaves unchanged each of those bits whose write-data bit is 1.
- R7: When a hardware event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R8: `rx_en` and `tx_en` equal `rx_req` and `tx_req` while status bit 10 is clear. Both are 0 from the cycle after `busrst_evt` until software clears bit 10.
- R9: Address 1 holds mask bits 15..10. `irq` is the OR of (flag AND mask) over bits 15..10. Bus-reset events leave the mask unchanged.
- R10: The read layout is as follows. Address 0 returns the flags in bits 15..10, zeros in bits 9..5, the direction in bit 4 and the endpoint in bits 3:0. Address 1 returns the mask in bits 15..10 and zeros elsewhere. Addresses 2 and 3 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of all registers |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| xfer_done | input | 1 | Endpoint transaction completion condition |
| xfer_dir | input | 1 | Direction of the completed transaction |
| xfer_ep | input | 4 | Endpoint index of the completed transaction |
| pma_late | input | 1 | Packet-memory request not served in time |
| err_timeout | input | 1 | Host response timeout |
| err_crc | input | 1 | CRC error in token or data |
| err_stuff | input | 1 | Bit-stuffing error |
| err_frame | input | 1 | Framing violation |
| wake_evt | input | 1 | Resume activity seen while suspended |
| susp_evt | input | 1 | Bus idle long enough to request suspend |
| busrst_evt | input | 1 | Reset detected on the USB bus |
| rx_req | input | 1 | Receive enable from the protocol logic |
| tx_req | input | 1 | Transmit enable from the protocol logic |
| rx_en | output | 1 | Gated receive enable |
| tx_en | output | 1 | Gated transmit enable |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest situation to reach from the ports is a software clear and a hardware set of the same flag in one cycle. The bench places an event pulse and a zero-write in the same cycle and reads the flag back afterwards. Masking and write-one-to-keep are swept over every combination of the five sticky flags. For each flag pattern, all 64 mask values and all 32 write patterns are applied, after the flags were raised by events. The interrupt, the read-back flags and the traffic enables are then compared with arithmetic expectations.

// File: rtl/usb_evt_status.sv
module usb_evt_status #(
  parameter int EP_W = 4,
  parameter int DW   = 16,
  parameter int AW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            xfer_done,
  input  logic            xfer_dir,
  input  logic [EP_W-1:0] xfer_ep,
  input  logic            pma_late,
  input  logic            err_timeout,
  input  logic            err_crc,
  input  logic            err_stuff,
  input  logic            err_frame,
  input  logic            wake_evt,
  input  logic            susp_evt,
  input  logic            busrst_evt,
  input  logic            rx_req,
  input  logic            tx_req,
  output logic            rx_en,
  output logic            tx_en,
  output logic            irq
);
  localparam int NF  = 6;
  localparam int FLO = DW - NF;
  localparam int PAD = FLO - EP_W - 1;

  logic [NF-1:0]   flg;
  logic [NF-1:0]   mask;
  logic            dir_q;
  logic [EP_W-1:0] ep_q;
  logic [NF-2:0]   hw_set;
  logic [NF-2:0]   keep;
  logic            wr_stat, wr_mask;

  assign hw_set  = {pma_late, err_timeout | err_crc | err_stuff | err_frame,
                    wake_evt, susp_evt, busrst_evt};
  assign wr_stat = bus_wr && (bus_addr == AW'(0));
  assign wr_mask = bus_wr && (bus_addr == AW'(1));
  assign keep    = wr_stat ? bus_wdata[DW-2:FLO] : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg   <= '0;
      mask  <= '0;
      dir_q <= 1'b0;
      ep_q  <= '0;
    end else begin
      flg[NF-1]   <= xfer_done;
      flg[NF-2:0] <= hw_set | (flg[NF-2:0] & keep);
      if (xfer_done && !flg[NF-1]) begin
        dir_q <= xfer_dir;
        ep_q  <= xfer_ep;
      end
      if (wr_mask) mask <= bus_wdata[DW-1:FLO];
    end
  end

  always_comb begin
    case (bus_addr)
      AW'(0):  bus_rdata = {flg, {PAD{1'b0}}, dir_q, ep_q};
      AW'(1):  bus_rdata = {mask, {FLO{1'b0}}};
      default: bus_rdata = '0;
    endcase
  end

  assign rx_en = rx_req & ~flg[0];
  assign tx_en = tx_req & ~flg[0];
  assign irq   = |(flg & mask);
endmodule

// File: rtl/usb_evt_status_chk.sv
module usb_evt_status_chk #(
  parameter int DW = 16,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          xfer_done,
  input logic          pma_late,
  input logic          wake_evt,
  input logic          susp_evt,
  input logic          busrst_evt,
  input logic          rx_en,
  input logic          tx_en,
  input logic          irq,
  input logic [5:0]    flg,
  input logic [5:0]    mask
);
  AST_CTR_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> flg[5] == $past(xfer_done)); // R1
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    pma_late |=> flg[4]); // R7
  AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == AW'(0) && !bus_wdata[DW-4] && !wake_evt |=> !flg[2]); // R6
  AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == AW'(0) && bus_wdata[DW-5] && flg[1] |=> flg[1]); // R6
  AST_TRAFFIC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busrst_evt |=> !rx_en && !tx_en); // R8
  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == AW'(1)) |=> $stable(mask)); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mask == '0 |-> !irq); // R9
endmodule

bind usb_evt_status usb_evt_status_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .xfer_done(xfer_done), .pma_late(pma_late),
  .wake_evt(wake_evt), .susp_evt(susp_evt), .busrst_evt(busrst_evt),
  .rx_en(rx_en), .tx_en(tx_en), .irq(irq), .flg(flg), .mask(mask)
);

// File: tb/test_usb_evt_status.sv
module test_usb_evt_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic xfer_done = 0, xfer_dir = 0;
  logic [3:0] xfer_ep = '0;
  logic pma_late = 0, err_timeout = 0, err_crc = 0, err_stuff = 0, err_frame = 0;
  logic wake_evt = 0, susp_evt = 0, busrst_evt = 0, rx_req = 1, tx_req = 1;
  logic rx_en, tx_en, irq;
  int vecs = 0, errs = 0;
  bit done = 0;

  always #5 clk = ~clk;

  usb_evt_status i_usb_evt_status (.*);

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic raise(logic [4:0] p);
    pma_late = p[4]; err_crc = p[3]; wake_evt = p[2]; susp_evt = p[1]; busrst_evt = p[0];
    @(negedge clk);
    {pma_late, err_crc, wake_evt, susp_evt, busrst_evt} = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errs++; vecs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(0, d); check("R10 reset status", d, 16'h0000);
    rd(1, d); check("R10 reset mask", d, 16'h0000);
    check("R9 reset irq", {15'd0, irq}, 16'd0);

    // R1 R2: capture on rise, hold while high
    xfer_dir = 1; xfer_ep = 4'd5; xfer_done = 1;
    @(negedge clk);
    xfer_dir = 0; xfer_ep = 4'd9;
    rd(0, d); check("R2 capture", d, 16'h8015);
    @(negedge clk);
    rd(0, d); check("R2 hold", d, 16'h8015);
    wr(0, 16'h0000);
    rd(0, d); check("R1 read-only", d, 16'h8015);
    wr(1, 16'h8000);
    check("R9 ctr irq", {15'd0, irq}, 16'd1);
    xfer_done = 0;
    @(negedge clk);
    rd(0, d); check("R1 self clear", d & 16'h8000, 16'h0000);
    check("R9 ctr irq low", {15'd0, irq}, 16'd0);

    // R4: each error source alone
    for (int s = 0; s < 4; s++) begin
      wr(0, 16'h0000);
      {err_timeout, err_crc, err_stuff, err_frame} = 4'b1000 >> s;
      @(negedge clk);
      {err_timeout, err_crc, err_stuff, err_frame} = '0;
      rd(0, d); check("R4 error merge", d & 16'hFC00, 16'h2000);
    end

    // R3 R5 R9: every flag pattern against every mask
    for (int p = 0; p < 32; p++) begin
      wr(0, 16'h0000);
      raise(5'(p));
      rd(0, d); check("R3 R5 flags", d & 16'hFC00, 16'(p) << 10);
      for (int m = 0; m < 64; m++) begin
        wr(1, 16'(m) << 10);
        check("R9 irq", {15'd0, irq}, {15'd0, |(p & m & 31)});
      end
      rd(1, d); check("R10 mask read", d, 16'hFC00);
    end

    // R6 R8: every flag pattern against every write pattern
    for (int p = 0; p < 32; p++)
      for (int w = 0; w < 32; w++) begin
        wr(0, 16'h0000);
        raise(5'(p));
        wr(0, 16'(w) << 10);
        rd(0, d); check("R6 clear", d & 16'hFC00, 16'(p & w) << 10);
        check("R8 rx", {15'd0, rx_en}, {15'd0, !((p & w & 1) != 0)});
        check("R8 tx", {15'd0, tx_en}, {15'd0, !((p & w & 1) != 0)});
      end

    // R7: set and clear in the same cycle
    wr(0, 16'h0000);
    pma_late = 1; wake_evt = 1;
    wr(0, 16'h0000);
    pma_late = 0; wake_evt = 0;
    rd(0, d); check("R7 set wins", d & 16'hFC00, 16'h5000);

    // R9: mask survives a bus reset; R8 traffic blocked then restored
    wr(1, 16'hA400);
    wr(0, 16'h0000);
    raise(5'b00001);
    rd(1, d); check("R9 mask kept", d, 16'hA400);
    check("R8 blocked", {14'd0, rx_en, tx_en}, 16'd0);
    rx_req = 0;
    wr(0, 16'h0000);
    check("R8 restored", {14'd0, rx_en, tx_en}, 16'd1);
    rx_req = 1;
    rd(2, d); check("R10 unused addr", d, 16'h0000);
    rd(3, d); check("R10 unused addr", d, 16'h0000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule